// File: doc/BRIEF.md
# EEPROM Page-Write and Status Engine

This block sits behind the bus front end of a byte-wide non-volatile memory model. Single-cycle write strobes are gathered into a page buffer. The buffer holds one page of `2**OFF_W` bytes (32 by default). The first write opens a load window of `LOAD_CYC` clocks. Each later write reopens that window. When the window expires with no further write, an internally timed programming cycle of `PROG_CYC` clocks runs. At its end, only the bytes that were actually loaded are copied into the behavioural array.

While a load or a program cycle is in progress, a read does not return array data. It returns a status byte with three progress indicators:
- an inverted copy of bit 7 of the last accepted byte,
- a bit that alternates on successive reads,
- a bit that shows whether the load window has closed.

A separate active-low busy output, modelled on an open-drain pin, is low for exactly the programming time.

Top module: `eeprom_page_engine`

## Requirements
- R1: After reset, busy_no is high, the engine is idle, and every array byte reads 8'hFF with status_hiz_o low.
- R2: A read strobe (rd_i high with wr_i low) gives rvalid_o high on the next cycle. When the engine is idle, rdata_o then holds the array byte at addr_i and status_hiz_o is low. When wr_i and rd_i are high together, the write is taken and no read result appears.
- R3: A write in the idle state opens the load window. Every write during the window restarts it. Programming starts `LOAD_CYC` clocks after the last write strobe if no further write arrives.
- R4: During the window, a byte is kept only if addr_i bits above the low `OFF_W` bits match the page of the opening write. A mismatched byte is dropped, but it still restarts the window.
- R5: Programming lasts exactly `PROG_CYC` clocks, with busy_no low for all of them. Writes during programming are ignored.
- R6: At the end of programming, only loaded offsets of the page are updated, and the last write to an offset wins. All other array bytes keep their contents.
- R7: A read while loading or programming returns the status byte. status_hiz_o is high and bits 4:0 are 0.
- R8: In the status byte, bit 7 is the complement of bit 7 of the last accepted byte when the read address equals that byte's address; for any other address it is 0. Once the engine is idle, the same address returns the true stored value.
- R9: Status bit 6 is 0 on the first status read of a write cycle and inverts on each further status read, across both the load and the program phases. It returns to 0 when the engine goes idle.
- R10: Status bit 5 is 0 while the load window is open and 1 during programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W | Byte address (page above the low OFF_W bits) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read result: array byte or status byte |
| rvalid_o | output | 1 | rdata_o valid, one cycle after a read strobe |
| status_hiz_o | output | 1 | Bits 4:0 of rdata_o are undriven (status byte) |
| busy_no | output | 1 | Low during programming |

## Verification
A wrong sequencer count shows up as a busy_no edge that is off by a cycle. The bench checks this edge at the exact cycle after a write, a restarted window and a dropped mismatched byte. A stale page mask or page register goes unnoticed until the engine is idle again. It then shows as a wrong byte when the bench reads back the whole page and bytes in neighbouring pages. A toggle flag that is not cleared, or a poll comparator that looks at the wrong address, is caught on the first status read of the following write cycle.

// File: rtl/epe_pkg.sv
package epe_pkg;
  localparam int DATA_W   = 8;
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int PLT_BIT  = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } epe_state_e;
endpackage

// File: rtl/epe_seq.sv
module epe_seq
  import epe_pkg::*;
#(
  parameter int LOAD_CYC = 12500,
  parameter int PROG_CYC = 625000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       page_hit_i,
  output epe_state_e state_o,
  output logic       start_o,
  output logic       accept_o,
  output logic       commit_o
);
  localparam int MAX_C = (LOAD_CYC > PROG_CYC) ? LOAD_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] LOAD_M1 = CNT_W'(LOAD_CYC - 1);
  localparam logic [CNT_W-1:0] PROG_M1 = CNT_W'(PROG_CYC - 1);

  epe_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign state_o  = state_q;
  assign start_o  = wr_i && (state_q == ST_IDLE);
  assign accept_o = start_o || (wr_i && (state_q == ST_LOAD) && page_hit_i);
  assign commit_o = (state_q == ST_PROG) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wr_i) begin
          state_q <= ST_LOAD;
          cnt_q   <= LOAD_M1;
        end
        ST_LOAD: begin
          // any write, kept or dropped, reopens the window
          if (wr_i) begin
            cnt_q <= LOAD_M1;
          end else if (cnt_q == '0) begin
            state_q <= ST_PROG;
            cnt_q   <= PROG_M1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PROG: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epe_page_buf.sv
module epe_page_buf
  import epe_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int OFF_W  = 5,
  localparam int PB    = 1 << OFF_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      accept_i,
  input  logic [PAGE_W-1:0]         wr_page_i,
  input  logic [OFF_W-1:0]          wr_off_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  output logic                      page_hit_o,
  output logic [PAGE_W-1:0]         page_o,
  output logic [PB-1:0]             mask_o,
  output logic [PB-1:0][DATA_W-1:0] data_o,
  output logic [OFF_W-1:0]          last_off_o,
  output logic                      last_msb_o
);
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  last_off_q;
  logic              last_msb_q;

  assign page_hit_o = (wr_page_i == page_q);
  assign page_o     = page_q;
  assign last_off_o = last_off_q;
  assign last_msb_o = last_msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q     <= '0;
      last_off_q <= '0;
      last_msb_q <= 1'b0;
    end else begin
      if (start_i) page_q <= wr_page_i;
      if (accept_i) begin
        last_off_q <= wr_off_i;
        last_msb_q <= wr_data_i[DATA_W-1];
      end
    end
  end

  for (genvar g = 0; g < PB; g++) begin : g_slot
    logic              sel;
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    assign sel = (wr_off_i == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else begin
        if (start_i)                vld_q <= sel;
        else if (accept_i && sel)   vld_q <= 1'b1;
        if (accept_i && sel)        dat_q <= wr_data_i;
      end
    end

    assign mask_o[g] = vld_q;
    assign data_o[g] = dat_q;
  end
endmodule

// File: rtl/epe_array.sv
module epe_array
  import epe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 5,
  localparam int PB     = 1 << OFF_W,
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      commit_i,
  input  logic [PAGE_W-1:0]         page_i,
  input  logic [PB-1:0]             mask_i,
  input  logic [PB-1:0][DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [DATA_W-1:0]         rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (commit_i) begin
      for (int j = 0; j < PB; j++)
        if (mask_i[j]) mem_q[{page_i, OFF_W'(j)}] <= data_i[j];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/epe_status.sv
module epe_status
  import epe_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_fire_i,
  input  epe_state_e        state_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic              last_msb_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              hiz_o
);
  logic              busy;
  logic              tog_q;
  logic [DATA_W-1:0] stat;

  assign busy = (state_i != ST_IDLE);

  always_comb begin
    stat           = '0;
    stat[POLL_BIT] = (rd_addr_i == last_addr_i) ? ~last_msb_i : 1'b0;
    stat[TOG_BIT]  = tog_q;
    stat[PLT_BIT]  = (state_i == ST_PROG);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q    <= 1'b0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      hiz_o    <= 1'b0;
    end else begin
      if (!busy)          tog_q <= 1'b0;
      else if (rd_fire_i) tog_q <= ~tog_q;
      rvalid_o <= rd_fire_i;
      if (rd_fire_i) begin
        rdata_o <= busy ? stat : mem_data_i;
        hiz_o   <= busy;
      end
    end
  end
endmodule

// File: rtl/eeprom_page_engine.sv
module eeprom_page_engine
  import epe_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int OFF_W    = 5,
  parameter int LOAD_CYC = 12500,
  parameter int PROG_CYC = 625000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              status_hiz_o,
  output logic              busy_no
);
  localparam int PB     = 1 << OFF_W;
  localparam int PAGE_W = ADDR_W - OFF_W;

  epe_state_e                state;
  logic                      start, accept, commit, page_hit, last_msb, rd_fire;
  logic [PAGE_W-1:0]         page;
  logic [PB-1:0]             mask;
  logic [PB-1:0][DATA_W-1:0] buf_data;
  logic [OFF_W-1:0]          last_off;
  logic [DATA_W-1:0]         mem_data;

  assign rd_fire = rd_i && !wr_i;
  assign busy_no = (state != ST_PROG);

  epe_seq #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk_i, .rst_ni, .wr_i,
    .page_hit_i(page_hit),
    .state_o   (state),
    .start_o   (start),
    .accept_o  (accept),
    .commit_o  (commit)
  );

  epe_page_buf #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_buf (
    .clk_i, .rst_ni,
    .start_i   (start),
    .accept_i  (accept),
    .wr_page_i (addr_i[ADDR_W-1:OFF_W]),
    .wr_off_i  (addr_i[OFF_W-1:0]),
    .wr_data_i (wdata_i),
    .page_hit_o(page_hit),
    .page_o    (page),
    .mask_o    (mask),
    .data_o    (buf_data),
    .last_off_o(last_off),
    .last_msb_o(last_msb)
  );

  epe_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_arr (
    .clk_i, .rst_ni,
    .commit_i (commit),
    .page_i   (page),
    .mask_i   (mask),
    .data_i   (buf_data),
    .rd_addr_i(addr_i),
    .rd_data_o(mem_data)
  );

  epe_status #(.ADDR_W(ADDR_W)) u_stat (
    .clk_i, .rst_ni,
    .rd_fire_i  (rd_fire),
    .state_i    (state),
    .rd_addr_i  (addr_i),
    .last_addr_i({page, last_off}),
    .last_msb_i (last_msb),
    .mem_data_i (mem_data),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o),
    .hiz_o      (status_hiz_o)
  );
endmodule

// File: rtl/eeprom_page_engine_chk.sv
module eeprom_page_engine_chk
  import epe_pkg::*;
#(
  parameter int PROG_CYC = 625000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic       rvalid_o,
  input logic       status_hiz_o,
  input logic       busy_no,
  input epe_state_e state_i
);
  logic [31:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lo_cnt <= '0;
    else if (!busy_no) lo_cnt <= lo_cnt + 1'b1;
    else               lo_cnt <= '0;
  end

  a_r2_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> rvalid_o);

  a_r2_no_stray_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && !wr_i) |=> !rvalid_o);

  a_r3_prog_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_no) |-> $past(state_i) == ST_LOAD);

  a_r5_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_no) |-> lo_cnt == PROG_CYC);

  a_r10_plts_in_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !$past(busy_no)) |-> (status_hiz_o && rdata_o[PLT_BIT]));

  a_r7_idle_drives_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(state_i) == ST_IDLE) |-> !status_hiz_o);
endmodule

bind eeprom_page_engine eeprom_page_engine_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o),
  .status_hiz_o(status_hiz_o),
  .busy_no     (busy_no),
  .state_i     (state)
);

// File: tb/eeprom_page_engine_tb.sv
`timescale 1ns/1ps
module eeprom_page_engine_tb;
  localparam int ADDR_W = 8;
  localparam int OFF_W  = 5;
  localparam int LC     = 16;
  localparam int PC     = 40;
  localparam int PB     = 1 << OFF_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_i = 1'b0, rd_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        wdata_i = '0;
  logic [7:0]        rdata_o;
  logic              rvalid_o, status_hiz_o, busy_no;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] model [1 << ADDR_W];

  always #4 clk_i = ~clk_i;

  eeprom_page_engine #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LOAD_CYC(LC), .PROG_CYC(PC)) u_dut (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
    .rdata_o, .rvalid_o, .status_hiz_o, .busy_no
  );

  function automatic logic [7:0] stat_exp(logic is_last, logic d7, logic tog, logic prog);
    logic [7:0] s;
    s = 8'h00;
    s[7] = is_last ? ~d7 : 1'b0;
    s[6] = tog;
    s[5] = prog;
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk_i); endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d, output logic h);
    rd_i = 1'b1; addr_i = a;
    tick();
    rd_i = 1'b0;
    chk("R2 valid", rvalid_o, 1);
    d = rdata_o; h = status_hiz_o;
  endtask

  task automatic rd_expect(string req, logic [ADDR_W-1:0] a, logic [7:0] ed, logic eh);
    logic [7:0] d; logic h;
    rd(a, d, h);
    chk(req, d, ed);
    chk(req, h, eh);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << ADDR_W); i++) model[i] = 8'hFF;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    chk("R1 busy", busy_no, 1);
    rd_expect("R1 erased", 8'h37, 8'hFF, 1'b0);
    rd_expect("R2 idle read", 8'hC0, 8'hFF, 1'b0);

    // R3 exact start, R8/R9/R10 status in programming, R5 write ignored
    wr(8'h40, 8'hA5);
    repeat (LC - 1) tick();
    chk("R3 still loading", busy_no, 1);
    tick();
    chk("R3 prog start", busy_no, 0);
    rd_expect("R8 poll first", 8'h40, stat_exp(1, 1, 0, 1), 1'b1);
    rd_expect("R9 toggle", 8'h40, stat_exp(1, 1, 1, 1), 1'b1);
    rd_expect("R8 other addr", 8'h41, stat_exp(0, 1, 0, 1), 1'b1);
    wr(8'h41, 8'h11);
    repeat (PC - 5) tick();
    chk("R5 busy held", busy_no, 0);
    tick();
    chk("R5 busy released", busy_no, 1);
    model[8'h40] = 8'hA5;
    rd_expect("R8 true value", 8'h40, 8'hA5, 1'b0);
    rd_expect("R5 write ignored", 8'h41, 8'hFF, 1'b0);

    // R10 load status, R4 mismatch drops byte but restarts window
    wr(8'h60, 8'h3C);
    rd_expect("R10 load status", 8'h60, stat_exp(1, 0, 0, 0), 1'b1);
    repeat (5) tick();
    wr(8'h61, 8'h5A);
    repeat (5) tick();
    wr(8'h85, 8'h77);
    repeat (LC - 1) tick();
    chk("R4 window restarted", busy_no, 1);
    tick();
    chk("R4 prog start", busy_no, 0);
    rd_expect("R9 toggle spans phases", 8'h61, stat_exp(1, 0, 1, 1), 1'b1);
    while (!busy_no) tick();
    model[8'h60] = 8'h3C; model[8'h61] = 8'h5A;
    rd_expect("R6 loaded 0", 8'h60, 8'h3C, 1'b0);
    rd_expect("R6 loaded 1", 8'h61, 8'h5A, 1'b0);
    rd_expect("R6 untouched", 8'h62, 8'hFF, 1'b0);
    rd_expect("R4 dropped", 8'h85, 8'hFF, 1'b0);

    // R2 write wins over read; R6 last write wins; R9 toggle cleared
    rd_i = 1'b1; wr_i = 1'b1; addr_i = 8'h70; wdata_i = 8'h01;
    tick();
    rd_i = 1'b0; wr_i = 1'b0;
    chk("R2 write priority", rvalid_o, 0);
    wr(8'h70, 8'h02);
    rd_expect("R9 cleared", 8'h70, stat_exp(1, 0, 0, 0), 1'b1);
    rd_expect("R7 low bits zero", 8'h71, stat_exp(0, 0, 1, 0), 1'b1);
    while (busy_no) tick();
    while (!busy_no) tick();
    model[8'h70] = 8'h02;
    rd_expect("R6 last write wins", 8'h70, 8'h02, 1'b0);

    // random page loads
    for (int it = 0; it < 12; it++) begin
      logic [2:0] pg;
      logic [7:0] pend [PB];
      logic [PB-1:0] pm;
      int nw, cnt;
      pg = 3'($urandom_range(0, 7));
      pm = '0;
      nw = $urandom_range(1, 6);
      for (int k = 0; k < nw; k++) begin
        logic [OFF_W-1:0] off;
        logic [7:0] d;
        logic [2:0] p;
        off = OFF_W'($urandom_range(0, PB - 1));
        d = 8'($urandom);
        p = (k > 0 && $urandom_range(0, 4) == 0) ? pg + 3'd1 : pg;
        wr({p, off}, d);
        if (p == pg) begin pend[off] = d; pm[off] = 1'b1; end
        repeat ($urandom_range(0, LC - 3)) tick();
      end
      cnt = 0;
      while (busy_no && cnt < LC + 2) begin tick(); cnt++; end
      chk("R3 random prog start", busy_no, 0);
      cnt = 0;
      while (!busy_no && cnt < PC + 4) begin tick(); cnt++; end
      chk("R5 random prog length", cnt, PC);
      for (int j = 0; j < PB; j++) if (pm[j]) model[{pg, OFF_W'(j)}] = pend[j];
      for (int j = 0; j < PB; j++)
        rd_expect("R6 random readback", {pg, OFF_W'(j)}, model[{pg, OFF_W'(j)}], 1'b0);
      rd_expect("R6 neighbour page", {pg + 3'd1, 5'd3}, model[{pg + 3'd1, 5'd3}], 1'b0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule